// File: doc/BRIEF.md
# Formatting Serial Receive Channel

This block receives serial words, one bit per serial clock edge, most significant bit first. A frame sync marks the first bit of each word. When a word is complete, the block formats it under a 2-bit data-type field and places it in a 32-bit parallel buffer, right-justified. The formatting can fill the unused upper bits with zeros, extend the word's sign into them, or treat the low eight bits as a G.711 code and expand it by the mu-law or A-law curve. A mode input selects standard operation or multichannel operation, and the two modes read the data-type field differently. A channel input, sampled with the frame sync, marks each word as primary or secondary, and the buffer reports that flag for the word it holds.

An enable input turns the channel on. A controller state machine moves through the states OFF, WARM0, WARM1, IDLE and SHIFT. It leaves OFF on the first clock edge that samples the enable high (transition OFF->WARM0). It then moves WARM0->WARM1->IDLE on the next two edges. IDLE->SHIFT is taken when the frame sync is sampled high. SHIFT->IDLE is taken on the edge that samples the last bit of the word. From any state, a low enable forces a move to OFF (transition abort), and clearing the enable also clears the buffer status flags.

The buffer side holds the full and overflow flags. A read strobe empties the buffer.

Top module: `rx_chan`

## Requirements
- R1: `ready` rises two clock edges after the edge that first samples `enable` high. Frame syncs and bits sampled before `ready` is high are ignored.
- R2: A low `enable` aborts any word in progress, drops `ready`, and clears `buf_full` and `overflow` on the next edge. A word started after re-enabling is received intact.
- R3: When `mc_mode`=0 and `dtype`=00, the received word is right-justified and the bits above it are zero.
- R4: When `mc_mode`=0 and `dtype`=01, the received word is right-justified and its top received bit is copied into every bit above it.
- R5: When `mc_mode`=0, `dtype`=10 and the word is primary, the low 8 bits are a mu-law code. The code is inverted bitwise; then bit 7 set means negative, bits 6:4 are the exponent e and bits 3:0 the mantissa m. The magnitude is ((2m+33)<<e)-33. The signed result is extended to 32 bits. Examples: code 80h gives 8031, code 00h gives -8031.
- R6: When `mc_mode`=0, `dtype`=11 and the word is primary, the low 8 bits are an A-law code. The code is XORed with 55h; then bit 7 clear means negative, with exponent in bits 6:4 and mantissa in bits 3:0. The magnitude is 2m+1 when e=0 and otherwise (2m+33)<<(e-1). The signed result is extended to 32 bits. Examples: D5h gives 1, 2Ah gives -4032.
- R7: When `mc_mode`=0 and the word is secondary (`sec_in`=1 at the frame sync), codes 10 and 11 deliver the word zero-filled, without expansion.
- R8: When `mc_mode`=1, expansion applies to every word on either channel. `dtype[1]` picks mu-law (0, 14-bit result) or A-law (1, 13-bit result). `dtype[0]` picks zero-fill (0) or sign-extend (1) above the result width.
- R9: `word_len` sets the word size from 3 to 32 bits, received most significant bit first.
- R10: Writing a formatted word sets `buf_full`. A `rd_strobe` pulse with no write in the same cycle clears it.
- R11: If a word completes while `buf_full` is set and no read occurs in that cycle, `overflow` is set. It stays set until the channel is disabled.
- R12: `buf_sec` gives the channel flag of the word held in `rx_buf`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Channel enable |
| mc_mode | input | 1 | 0 standard, 1 multichannel |
| dtype | input | 2 | Data-type formatting field |
| word_len | input | 6 | Word length in bits, 3 to 32 |
| rx_bit | input | 1 | Serial data in |
| frame_sync | input | 1 | High with the first bit of a word |
| sec_in | input | 1 | Channel of the word starting now (1 = secondary) |
| rd_strobe | input | 1 | Read pulse that empties the buffer |
| rx_buf | output | 32 | Formatted received word |
| buf_sec | output | 1 | Channel flag of the buffered word |
| buf_full | output | 1 | Buffer holds an unread word |
| overflow | output | 1 | A word arrived while the buffer was full |
| ready | output | 1 | Channel accepts frame syncs |

## Verification
The edge that samples the last bit of a word also registers the completed word. The formatted result, `buf_full` and `buf_sec` change one edge later, so each word check samples at the second falling edge after that last bit. `ready` is due after the third rising edge that samples `enable` high, so the warm-up checks sample at the falling edges between those rising edges and observe it low, low and then high. A read or a disable takes effect on the first rising edge after it is driven, and each such check samples at the falling edge that follows.

// File: rtl/rx_chan_pkg.sv
package rx_chan_pkg;
    typedef enum logic [2:0] {
        S_OFF   = 3'd0,
        S_WARM0 = 3'd1,
        S_WARM1 = 3'd2,
        S_IDLE  = 3'd3,
        S_SHIFT = 3'd4
    } rx_state_e;
endpackage

// File: rtl/rx_ctrl_fsm.sv
module rx_ctrl_fsm
    import rx_chan_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LEN_W  = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              rx_bit,
    input  logic              frame_sync,
    input  logic              sec_in,
    input  logic [LEN_W-1:0]  word_len,
    output logic              ready,
    output logic              done_q,
    output logic [DATA_W-1:0] word_q,
    output logic              word_sec_q
);
    rx_state_e         state, state_nx;
    logic [DATA_W-1:0] shreg;
    logic [LEN_W-1:0]  cnt;
    logic              sec_q;
    logic              last_bit;
    logic [DATA_W-1:0] shifted;

    assign last_bit = (cnt == word_len - LEN_W'(1));
    assign shifted  = {shreg[DATA_W-2:0], rx_bit};

    // next-state logic
    always_comb begin
        state_nx = state;
        if (!enable) begin
            state_nx = S_OFF;
        end else begin
            unique case (state)
                S_OFF:   state_nx = S_WARM0;
                S_WARM0: state_nx = S_WARM1;
                S_WARM1: state_nx = S_IDLE;
                S_IDLE:  if (frame_sync) state_nx = S_SHIFT;
                S_SHIFT: if (last_bit) state_nx = S_IDLE;
                default: state_nx = S_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_OFF;
        else        state <= state_nx;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg      <= '0;
            cnt        <= '0;
            sec_q      <= 1'b0;
            done_q     <= 1'b0;
            word_q     <= '0;
            word_sec_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (enable && state == S_IDLE && frame_sync) begin
                shreg <= {{(DATA_W-1){1'b0}}, rx_bit};
                cnt   <= LEN_W'(1);
                sec_q <= sec_in;
            end else if (enable && state == S_SHIFT) begin
                shreg <= shifted;
                cnt   <= cnt + LEN_W'(1);
                if (last_bit) begin
                    done_q     <= 1'b1;
                    word_q     <= shifted;
                    word_sec_q <= sec_q;
                end
            end
        end
    end

    assign ready = (state == S_IDLE) || (state == S_SHIFT);

    // R1
    warmup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> ($past(enable) && $past(enable, 2)));

    // R2
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (state == S_OFF) && !done_q);
endmodule

// File: rtl/g711_expand.sv
module g711_expand (
    input  logic [7:0]  code,
    input  logic        a_law,
    output logic [13:0] value
);
    logic [7:0]  c;
    logic [2:0]  ex;
    logic [3:0]  mt;
    logic        neg;
    logic [13:0] mag;

    always_comb begin
        c   = a_law ? (code ^ 8'h55) : ~code;
        ex  = c[6:4];
        mt  = c[3:0];
        if (a_law) begin
            neg = ~c[7];
            if (ex == 3'd0) mag = 14'({mt, 1'b1});
            else            mag = 14'({1'b1, mt, 1'b1}) << (ex - 3'd1);
        end else begin
            neg = c[7];
            mag = (14'({1'b1, mt, 1'b1}) << ex) - 14'd33;
        end
        value = neg ? (14'd0 - mag) : mag;
    end
endmodule

// File: rtl/rx_formatter.sv
module rx_formatter #(
    parameter int DATA_W = 32,
    parameter int LEN_W  = $clog2(DATA_W + 1)
) (
    input  logic [DATA_W-1:0] raw,
    input  logic [LEN_W-1:0]  len,
    input  logic [1:0]        dtype,
    input  logic              mc,
    input  logic              sec,
    output logic [DATA_W-1:0] fmt
);
    localparam int MU_W = 14;
    localparam int A_W  = 13;

    logic [13:0]       law_val;
    logic              a_sel, use_law, fill_sign, plain_sext, top_bit, law_sign;
    logic [DATA_W-1:0] plain, expanded;
    int                law_w;

    assign a_sel     = mc ? dtype[1] : dtype[0];
    assign use_law   = mc || (dtype[1] && !sec);
    assign fill_sign = mc ? dtype[0] : 1'b1;
    assign plain_sext = (dtype == 2'b01);
    assign top_bit   = raw[len - LEN_W'(1)];
    assign law_w     = a_sel ? A_W : MU_W;
    assign law_sign  = a_sel ? law_val[A_W-1] : law_val[MU_W-1];

    g711_expand u_exp (
        .code  (raw[7:0]),
        .a_law (a_sel),
        .value (law_val)
    );

    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            if (LEN_W'(i) < len) plain[i] = raw[i];
            else                 plain[i] = plain_sext & top_bit;
            if (i < law_w)       expanded[i] = law_val[i];
            else                 expanded[i] = fill_sign & law_sign;
        end
    end

    assign fmt = use_law ? expanded : plain;
endmodule

// File: rtl/rx_chan.sv
module rx_chan #(
    parameter int DATA_W = 32,
    parameter int LEN_W  = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              mc_mode,
    input  logic [1:0]        dtype,
    input  logic [LEN_W-1:0]  word_len,
    input  logic              rx_bit,
    input  logic              frame_sync,
    input  logic              sec_in,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rx_buf,
    output logic              buf_sec,
    output logic              buf_full,
    output logic              overflow,
    output logic              ready
);
    logic              done_q, word_sec_q;
    logic [DATA_W-1:0] word_q, fmt;

    rx_ctrl_fsm #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .rx_bit     (rx_bit),
        .frame_sync (frame_sync),
        .sec_in     (sec_in),
        .word_len   (word_len),
        .ready      (ready),
        .done_q     (done_q),
        .word_q     (word_q),
        .word_sec_q (word_sec_q)
    );

    rx_formatter #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_fmt (
        .raw   (word_q),
        .len   (word_len),
        .dtype (dtype),
        .mc    (mc_mode),
        .sec   (word_sec_q),
        .fmt   (fmt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_buf   <= '0;
            buf_sec  <= 1'b0;
            buf_full <= 1'b0;
            overflow <= 1'b0;
        end else if (!enable) begin
            buf_full <= 1'b0;
            overflow <= 1'b0;
        end else if (done_q) begin
            rx_buf   <= fmt;
            buf_sec  <= word_sec_q;
            buf_full <= 1'b1;
            if (buf_full && !rd_strobe) overflow <= 1'b1;
        end else if (rd_strobe) begin
            buf_full <= 1'b0;
        end
    end

    // R2
    status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !buf_full && !overflow);

    // R10
    fill_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && enable) |=> buf_full);

    // R11
    overflow_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(buf_full) && $past(done_q));
endmodule

// File: tb/tb_rx_chan.sv
module tb_rx_chan;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0, mc_mode = 1'b0, rx_bit = 1'b0;
    logic        frame_sync = 1'b0, sec_in = 1'b0, rd_strobe = 1'b0;
    logic [1:0]  dtype = 2'b00;
    logic [5:0]  word_len = 6'd8;
    logic [31:0] rx_buf;
    logic        buf_sec, buf_full, overflow, ready;

    int checks = 0, fails = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_chan dut (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic send_word(input int len, input logic [31:0] data, input logic sec);
        for (int i = len - 1; i >= 0; i--) begin
            @(negedge clk);
            frame_sync = (i == len - 1);
            rx_bit     = data[i];
            sec_in     = sec;
        end
        @(negedge clk);
        frame_sync = 1'b0; rx_bit = 1'b0; sec_in = 1'b0;
        @(negedge clk);
    endtask

    task automatic read_buf();
        @(negedge clk); rd_strobe = 1'b1;
        @(negedge clk); rd_strobe = 1'b0;
    endtask

    task automatic cfg(input logic mc, input logic [1:0] dt, input int len);
        @(negedge clk);
        mc_mode = mc; dtype = dt; word_len = 6'(len);
    endtask

    task automatic word_test(input string tag, input int len, input logic [31:0] data,
                             input logic sec, input logic [31:0] exp);
        send_word(len, data, sec);
        check(tag, rx_buf, exp);
        check({tag, " full"}, {31'd0, buf_full}, 32'd1);
        check({tag, " chan"}, {31'd0, buf_sec}, {31'd0, sec});
        read_buf();
    endtask

    task automatic t_warmup();
        @(negedge clk); enable = 1'b1;
        @(negedge clk);
        check("R1 ready low 1", {31'd0, ready}, 32'd0);
        frame_sync = 1'b1; rx_bit = 1'b1;
        @(negedge clk);
        check("R1 ready low 2", {31'd0, ready}, 32'd0);
        frame_sync = 1'b0;
        @(negedge clk);
        check("R1 ready high", {31'd0, ready}, 32'd1);
        rx_bit = 1'b0;
        repeat (6) @(negedge clk);
        check("R1 early sync ignored", {31'd0, buf_full}, 32'd0);
    endtask

    task automatic t_standard();
        cfg(1'b0, 2'b00, 12);
        word_test("R3 zero-fill", 12, 32'h0000_0A5C, 1'b0, 32'h0000_0A5C);
        cfg(1'b0, 2'b01, 12);
        word_test("R4 sign-extend", 12, 32'h0000_0A5C, 1'b0, 32'hFFFF_FA5C);
        word_test("R4 positive", 12, 32'h0000_05A3, 1'b0, 32'h0000_05A3);
        cfg(1'b0, 2'b10, 8);
        word_test("R5 mu 80h", 8, 32'h80, 1'b0, 32'h0000_1F5F);
        word_test("R5 mu 00h", 8, 32'h00, 1'b0, 32'hFFFF_E0A1);
        word_test("R5 mu FFh", 8, 32'hFF, 1'b0, 32'h0000_0000);
        word_test("R7 mu secondary", 8, 32'h80, 1'b1, 32'h0000_0080);
        cfg(1'b0, 2'b11, 8);
        word_test("R6 A D5h", 8, 32'hD5, 1'b0, 32'h0000_0001);
        word_test("R6 A 2Ah", 8, 32'h2A, 1'b0, 32'hFFFF_F040);
        word_test("R7 A secondary", 8, 32'hAA, 1'b1, 32'h0000_00AA);
        word_test("R12 primary after secondary", 8, 32'hAA, 1'b0, 32'h0000_0FC0);
    endtask

    task automatic t_multichannel();
        cfg(1'b1, 2'b00, 8);
        word_test("R8 mu zero-fill", 8, 32'h00, 1'b0, 32'h0000_20A1);
        cfg(1'b1, 2'b01, 8);
        word_test("R8 mu sign-extend", 8, 32'h00, 1'b0, 32'hFFFF_E0A1);
        cfg(1'b1, 2'b10, 8);
        word_test("R8 A zero-fill", 8, 32'h2A, 1'b0, 32'h0000_1040);
        cfg(1'b1, 2'b11, 8);
        word_test("R8 A sign-extend", 8, 32'h2A, 1'b0, 32'hFFFF_F040);
        word_test("R8 A secondary", 8, 32'hAA, 1'b1, 32'h0000_0FC0);
        word_test("R8 A secondary negative", 8, 32'h2A, 1'b1, 32'hFFFF_F040);
    endtask

    task automatic t_lengths();
        cfg(1'b0, 2'b01, 3);
        word_test("R9 3-bit", 3, 32'h5, 1'b0, 32'hFFFF_FFFD);
        cfg(1'b0, 2'b00, 32);
        word_test("R9 32-bit", 32, 32'hDEAD_BEEF, 1'b0, 32'hDEAD_BEEF);
    endtask

    task automatic t_status();
        cfg(1'b0, 2'b00, 8);
        send_word(8, 32'h11, 1'b0);
        check("R10 full after write", {31'd0, buf_full}, 32'd1);
        check("R11 no overflow yet", {31'd0, overflow}, 32'd0);
        send_word(8, 32'h22, 1'b0);
        check("R11 overflow set", {31'd0, overflow}, 32'd1);
        check("R11 newest word kept", rx_buf, 32'h22);
        read_buf();
        check("R10 read clears full", {31'd0, buf_full}, 32'd0);
        check("R11 overflow sticky", {31'd0, overflow}, 32'd1);
        @(negedge clk); enable = 1'b0;
        @(negedge clk);
        check("R2 disable clears overflow", {31'd0, overflow}, 32'd0);
        check("R2 disable drops ready", {31'd0, ready}, 32'd0);
    endtask

    task automatic t_abort();
        @(negedge clk); enable = 1'b1;
        repeat (3) @(negedge clk);
        cfg(1'b0, 2'b00, 12);
        for (int i = 11; i >= 7; i--) begin
            @(negedge clk);
            frame_sync = (i == 11); rx_bit = 1'b1;
        end
        @(negedge clk); frame_sync = 1'b0; enable = 1'b0;
        repeat (10) @(negedge clk);
        check("R2 abort no word", {31'd0, buf_full}, 32'd0);
        enable = 1'b1;
        repeat (3) @(negedge clk);
        check("R2 ready after re-enable", {31'd0, ready}, 32'd1);
        word_test("R2 clean word after abort", 12, 32'h0000_0123, 1'b0, 32'h0000_0123);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("reset full", {31'd0, buf_full}, 32'd0);
        check("reset overflow", {31'd0, overflow}, 32'd0);
        check("reset ready", {31'd0, ready}, 32'd0);
        rst_n = 1'b1;
        t_warmup();
        t_standard();
        t_multichannel();
        t_lengths();
        t_status();
        t_abort();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule